// File: doc/BRIEF.md
# Secure/Privileged Register Access Filter

This block guards a small power-controller register file against accesses that lack the right security or privilege level. Each bus request carries a secure qualifier and a privileged qualifier. For every bit of the addressed register, the block decides whether a write lands and whether a read returns the stored value or zero. A denied access still completes normally, and no error is signalled.

The decision depends on four things. The first is a global security-enable input. The second is a security configuration register with one bit per item group; a set bit makes that group secure. The third and fourth are two bits in a privilege configuration register. One requires privilege for secure items. The other requires privilege for non-secure items.

Functional registers are modelled as a generic array. Each bit maps to an item group through a fixed formula, so allowed and denied bits in the same word are handled independently in one access.

Top module: `accessFilter`

## Requirements
- R1: After reset every register holds zero, both configuration registers are zero, and any combination of secure and privileged qualifiers may read and write the functional registers (addresses 2 to 7).
- R2: While `secEn` is 0, the security configuration register (address 0) reads as zero and ignores writes. Every functional bit is then treated as non-secure, whatever the stored security bits hold.
- R3: Bit b of functional register at address a belongs to group (a-2+b) mod 5. When `secEn` is 1 and that group's bit in the security configuration register is set, the bit is secure. A non-secure write leaves a secure bit unchanged, and a non-secure read returns 0 for it. Other bits of the same word follow their own rules within the same access.
- R4: In the privilege configuration register (address 1), bit 0 (secure-privilege) changes only on a secure privileged write, and bit 1 (non-secure-privilege) changes only on a privileged write. Both bits read back for any access, and bits 15..2 read 0.
- R5: While bit 0 of the privilege configuration register is 1, secure functional bits and the security configuration register accept writes only from secure privileged accesses. Secure functional bits are readable only by secure privileged accesses. The security configuration register stays readable by any access.
- R6: While bit 1 of the privilege configuration register is 1, unprivileged accesses cannot write non-secure functional bits and read them as 0. The exception is the status register at address 7, whose non-secure bits stay readable without privilege.
- R7: `rdData` reflects a read in the same cycle as the request and is 0 when `reqValid` is 0 or `reqWrite` is 1. A write becomes visible from the clock edge that accepts it, and a request with `reqValid` low changes nothing.
- R8: While `secEn` is 1, the security configuration register (bits 4..0, one per group) accepts writes only from secure accesses. Any access reads its stored value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| secEn | input | 1 | Global security enable |
| reqValid | input | 1 | Request present this cycle |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqAddr | input | 3 | Register address |
| reqWdata | input | 16 | Write data |
| reqSecure | input | 1 | Request is secure |
| reqPriv | input | 1 | Request is privileged |
| rdData | output | 16 | Filtered read data, same cycle |

## Verification
Read results are combinational, so each read is due in the cycle it is presented. The bench drives each request just after the falling edge and compares `rdData` one nanosecond later, before the rising edge. Write effects are due from the next rising edge. The behavioural model commits its own state only after that edge, so the first request that can observe a write is the one in the following cycle. Every cycle, including idle ones, is compared against the model.

// File: rtl/accessFilterPkg.sv
package accessFilterPkg;

  typedef struct packed {
    logic wrStb;
    logic rdStb;
  } accStb_t;

  // item group that owns bit bitPos of functional register idx
  function automatic int groupOf(int idx, int bitPos, int groups);
    return (idx + bitPos) % groups;
  endfunction

endpackage

// File: rtl/accessCtrl.sv
module accessCtrl
  import accessFilterPkg::*;
#(
  parameter int DATA_W      = 16,
  parameter int NUM_REGS    = 8,
  parameter int NUM_GROUPS  = 5,
  parameter int STATUS_ADDR = 7,
  localparam int ADDR_W     = $clog2(NUM_REGS)
) (
  input  logic                  reqValid,
  input  logic                  reqWrite,
  input  logic [ADDR_W-1:0]     reqAddr,
  input  logic                  reqSecure,
  input  logic                  reqPriv,
  input  logic                  secEn,
  input  logic [NUM_GROUPS-1:0] secCfg,
  input  logic [1:0]            privCfg,
  output accStb_t               stb,
  output logic [DATA_W-1:0]     wrMask,
  output logic [DATA_W-1:0]     rdMask
);
  localparam int SEC_ADDR  = 0;
  localparam int PRIV_ADDR = 1;
  localparam int FUNC_BASE = 2;

  logic secPriv, nsPriv, secOk;
  logic [DATA_W-1:0] wrAllow;

  assign secPriv = privCfg[0];
  assign nsPriv  = privCfg[1];
  assign secOk   = reqSecure && (!secPriv || reqPriv);

  assign stb.wrStb = reqValid && reqWrite;
  assign stb.rdStb = reqValid && !reqWrite;

  always_comb begin
    int g;
    logic isSec;
    wrAllow = '0;
    rdMask  = '0;
    g       = 0;
    isSec   = 1'b0;
    if (int'(reqAddr) == SEC_ADDR) begin
      if (secEn) begin
        rdMask[NUM_GROUPS-1:0] = '1;
        if (secOk) wrAllow[NUM_GROUPS-1:0] = '1;
      end
    end else if (int'(reqAddr) == PRIV_ADDR) begin
      rdMask[1:0] = 2'b11;
      wrAllow[0]  = reqSecure && reqPriv;
      wrAllow[1]  = reqPriv;
    end else begin
      for (int b = 0; b < DATA_W; b++) begin
        g     = groupOf(int'(reqAddr) - FUNC_BASE, b, NUM_GROUPS);
        isSec = secEn && secCfg[g];
        if (isSec) begin
          wrAllow[b] = secOk;
          rdMask[b]  = secOk;
        end else begin
          wrAllow[b] = !nsPriv || reqPriv;
          rdMask[b]  = !nsPriv || reqPriv || (int'(reqAddr) == STATUS_ADDR);
        end
      end
    end
  end

  assign wrMask = stb.wrStb ? wrAllow : '0;

  // a disabled security scheme may never produce a write to the security config
  always_comb begin
    if (!secEn && int'(reqAddr) == SEC_ADDR)
      assert_secdis_nowrite_R2: assert (wrMask == '0);
  end

endmodule

// File: rtl/accessRegs.sv
module accessRegs
  import accessFilterPkg::*;
#(
  parameter int DATA_W     = 16,
  parameter int NUM_REGS   = 8,
  parameter int NUM_GROUPS = 5,
  localparam int ADDR_W    = $clog2(NUM_REGS)
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  secEn,
  input  accStb_t               stb,
  input  logic [ADDR_W-1:0]     reqAddr,
  input  logic [DATA_W-1:0]     reqWdata,
  input  logic [DATA_W-1:0]     wrMask,
  input  logic [DATA_W-1:0]     rdMask,
  output logic [NUM_GROUPS-1:0] secCfg,
  output logic [1:0]            privCfg,
  output logic [DATA_W-1:0]     rdData
);
  logic [NUM_REGS-1:0][DATA_W-1:0] regQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      regQ <= '0;
    end else if (stb.wrStb) begin
      regQ[reqAddr] <= (regQ[reqAddr] & ~wrMask) | (reqWdata & wrMask);
    end
  end

  assign secCfg  = regQ[0][NUM_GROUPS-1:0];
  assign privCfg = regQ[1][1:0];
  assign rdData  = stb.rdStb ? (regQ[reqAddr] & rdMask) : '0;

  assert_secdis_stable_R2: assert property (@(posedge clk) disable iff (!rstN)
    !secEn |=> $stable(secCfg));

  assert_idle_nochange_R7: assert property (@(posedge clk) disable iff (!rstN)
    !stb.wrStb |=> $stable(regQ));

endmodule

// File: rtl/accessFilter.sv
module accessFilter
  import accessFilterPkg::*;
#(
  parameter int DATA_W      = 16,
  parameter int NUM_REGS    = 8,
  parameter int NUM_GROUPS  = 5,
  parameter int STATUS_ADDR = 7,
  localparam int ADDR_W     = $clog2(NUM_REGS)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              secEn,
  input  logic              reqValid,
  input  logic              reqWrite,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqWdata,
  input  logic              reqSecure,
  input  logic              reqPriv,
  output logic [DATA_W-1:0] rdData
);
  accStb_t               stb;
  logic [DATA_W-1:0]     wrMask, rdMask;
  logic [NUM_GROUPS-1:0] secCfg;
  logic [1:0]            privCfg;

  accessCtrl #(.DATA_W(DATA_W), .NUM_REGS(NUM_REGS), .NUM_GROUPS(NUM_GROUPS),
               .STATUS_ADDR(STATUS_ADDR)) uCtrl (
    .reqValid(reqValid), .reqWrite(reqWrite), .reqAddr(reqAddr),
    .reqSecure(reqSecure), .reqPriv(reqPriv), .secEn(secEn),
    .secCfg(secCfg), .privCfg(privCfg), .stb(stb),
    .wrMask(wrMask), .rdMask(rdMask));

  accessRegs #(.DATA_W(DATA_W), .NUM_REGS(NUM_REGS), .NUM_GROUPS(NUM_GROUPS)) uRegs (
    .clk(clk), .rstN(rstN), .secEn(secEn), .stb(stb), .reqAddr(reqAddr),
    .reqWdata(reqWdata), .wrMask(wrMask), .rdMask(rdMask),
    .secCfg(secCfg), .privCfg(privCfg), .rdData(rdData));

  assert_secpriv_guard_R4: assert property (@(posedge clk) disable iff (!rstN)
    !(reqValid && reqWrite && reqSecure && reqPriv && int'(reqAddr) == 1)
    |=> $stable(privCfg[0]));

  assert_noread_zero_R7: assert property (@(posedge clk) disable iff (!rstN)
    !(reqValid && !reqWrite) |-> rdData == '0);

  assert_ns_allsec_zero_R3: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && !reqWrite && !reqSecure && secEn && (&secCfg) && int'(reqAddr) >= 2)
    |-> rdData == '0);

endmodule

// File: tb/tb_accessFilter.sv
module tb_accessFilter;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic secEn = 1'b0;
  logic reqValid = 1'b0, reqWrite = 1'b0, reqSecure = 1'b0, reqPriv = 1'b0;
  logic [2:0]  reqAddr = '0;
  logic [15:0] reqWdata = '0;
  logic [15:0] rdData;

  int checks = 0;
  int errors = 0;
  logic [15:0] m [8];

  always #2 clk = ~clk;

  accessFilter dut (.clk(clk), .rstN(rstN), .secEn(secEn), .reqValid(reqValid),
    .reqWrite(reqWrite), .reqAddr(reqAddr), .reqWdata(reqWdata),
    .reqSecure(reqSecure), .reqPriv(reqPriv), .rdData(rdData));

  function automatic bit secBit(int a, int b);
    return secEn && m[0][(a - 2 + b) % 5];
  endfunction

  function automatic bit canRead(int a, int b, bit s, bit p);
    if (a == 0) return secEn && b < 5;
    if (a == 1) return b < 2;
    if (secBit(a, b)) return s && (!m[1][0] || p);
    return !m[1][1] || p || a == 7;
  endfunction

  function automatic bit canWrite(int a, int b, bit s, bit p);
    if (a == 0) return secEn && b < 5 && s && (!m[1][0] || p);
    if (a == 1) return (b == 0) ? (s && p) : (b == 1) ? p : 1'b0;
    if (secBit(a, b)) return s && (!m[1][0] || p);
    return !m[1][1] || p;
  endfunction

  task automatic step(bit v, bit w, int a, logic [15:0] d, bit s, bit p, string tag);
    logic [15:0] exp, nxt;
    @(negedge clk);
    reqValid = v; reqWrite = w; reqAddr = 3'(a); reqWdata = d;
    reqSecure = s; reqPriv = p;
    #1;
    exp = '0;
    nxt = m[a];
    for (int b = 0; b < 16; b++) begin
      if (v && !w && canRead(a, b, s, p)) exp[b] = m[a][b];
      if (v && w && canWrite(a, b, s, p)) nxt[b] = d[b];
    end
    checks++;
    if (rdData !== exp) begin
      errors++;
      $display("FAIL %s: addr %0d rdData=%h expected=%h", tag, a, rdData, exp);
    end
    @(posedge clk);
    m[a] = nxt;
  endtask

  task automatic rd(int a, bit s, bit p, string tag);
    step(1'b1, 1'b0, a, 16'h0, s, p, tag);
  endtask

  task automatic wr(int a, logic [15:0] d, bit s, bit p, string tag);
    step(1'b1, 1'b1, a, d, s, p, tag);
  endtask

  initial begin
    #400000;
    errors++;
    $display("FAIL watchdog: run did not complete, expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < 8; i++) m[i] = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // R1: reset values and open access
    for (int a = 0; a < 8; a++) rd(a, 1'b1, 1'b1, "R1");
    wr(2, 16'hA5A5, 1'b0, 1'b0, "R1");
    rd(2, 1'b0, 1'b0, "R1");
    // R2: security disabled
    wr(0, 16'h001F, 1'b1, 1'b1, "R2");
    rd(0, 1'b1, 1'b1, "R2");
    wr(3, 16'h1234, 1'b0, 1'b0, "R2");
    rd(3, 1'b0, 1'b0, "R2");
    // R8: security configuration under global enable
    secEn = 1'b1;
    wr(0, 16'h001F, 1'b0, 1'b1, "R8");
    rd(0, 1'b0, 1'b0, "R8");
    wr(0, 16'h0005, 1'b1, 1'b0, "R8");
    rd(0, 1'b0, 1'b0, "R8");
    // R3: per-bit filtering by group
    wr(2, 16'hFFFF, 1'b0, 1'b0, "R3");
    rd(2, 1'b0, 1'b0, "R3");
    rd(2, 1'b1, 1'b0, "R3");
    wr(4, 16'h0F0F, 1'b1, 1'b0, "R3");
    rd(4, 1'b0, 1'b1, "R3");
    rd(4, 1'b1, 1'b1, "R3");
    // R4: privilege configuration writes
    wr(1, 16'h0003, 1'b1, 1'b0, "R4");
    rd(1, 1'b0, 1'b0, "R4");
    wr(1, 16'hFFFF, 1'b0, 1'b1, "R4");
    rd(1, 1'b0, 1'b0, "R4");
    wr(1, 16'h0001, 1'b1, 1'b1, "R4");
    rd(1, 1'b0, 1'b0, "R4");
    // R5: secure-privilege set
    wr(4, 16'hFFFF, 1'b1, 1'b0, "R5");
    rd(4, 1'b1, 1'b0, "R5");
    rd(4, 1'b1, 1'b1, "R5");
    wr(4, 16'hFFFF, 1'b1, 1'b1, "R5");
    rd(4, 1'b1, 1'b1, "R5");
    wr(0, 16'h001F, 1'b1, 1'b0, "R5");
    rd(0, 1'b0, 1'b0, "R5");
    wr(0, 16'h001B, 1'b1, 1'b1, "R5");
    rd(0, 1'b0, 1'b0, "R5");
    // R6: non-secure-privilege set, status exception
    wr(1, 16'h0003, 1'b1, 1'b1, "R6");
    wr(5, 16'hFFFF, 1'b0, 1'b0, "R6");
    rd(5, 1'b0, 1'b1, "R6");
    wr(5, 16'hC3C3, 1'b0, 1'b1, "R6");
    rd(5, 1'b0, 1'b0, "R6");
    rd(5, 1'b0, 1'b1, "R6");
    wr(7, 16'hFFFF, 1'b1, 1'b1, "R6");
    rd(7, 1'b0, 1'b0, "R6");
    rd(7, 1'b1, 1'b0, "R6");
    // R7: idle, invalid writes, same-cycle reads
    step(1'b0, 1'b1, 6, 16'hBEEF, 1'b1, 1'b1, "R7");
    step(1'b0, 1'b0, 6, 16'h0, 1'b1, 1'b1, "R7");
    rd(6, 1'b1, 1'b1, "R7");
    wr(6, 16'h7E57, 1'b1, 1'b1, "R7");
    rd(6, 1'b1, 1'b1, "R7");
    // R2: dropping the enable makes every bit non-secure again
    secEn = 1'b0;
    rd(0, 1'b1, 1'b1, "R2");
    rd(4, 1'b0, 1'b1, "R2");
    wr(4, 16'h0000, 1'b0, 1'b1, "R2");
    rd(4, 1'b0, 1'b1, "R2");
    repeat (2) step(1'b0, 1'b0, 0, 16'h0, 1'b0, 1'b0, "R7");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule